// File: doc/BRIEF.md
# Keyed Write Unlock Gate

This block guards a register file that runs on a slow clock. It sits between that file and a bus that runs on a fast clock. A write to any protected address gets through only if two things happened first. Software must have written the exact unlock key to the key address. The gate must also report itself open. Each accepted write uses up the unlock, so the next protected write needs a new key. Software reads the open state in the top bit of the key address.

An accepted write is held in the fast domain. It is handed to the slow domain with a toggle handshake. The slow side sees a one-cycle write strobe together with the address and data, and then sends an acknowledge back. While that round trip is in flight, the ready bit (bit 7 of the control address) reads low. The gate ignores every write, key or protected, until the acknowledge has come back.

Reads are never gated. Every address returns the register file's read data. The only changes are at the key address, which returns the open flag, and at the control address, which has its ready bit replaced.

Top module: `wr_key_gate`

## Requirements
- R1: After reset the gate is locked. Reading address 0x3C returns 0, reading address 0x00 shows the ready bit (bit 7) at 1, and no write reaches the slow side.
- R2: A write of exactly 0x0000A55A to address 0x3C, made while ready is 1, opens the gate. From the next cycle, bit 31 of address 0x3C reads 1.
- R3: A write of any other value to address 0x3C, made while ready is 1, leaves the gate locked and clears bit 31 of address 0x3C.
- R4: A write to any address other than 0x3C, made while the gate is open and ready is 1, appears on the slow side exactly once. It arrives as a single-cycle strobe carrying that address and data, and the address and data stay stable until the acknowledge returns.
- R5: The cycle after a protected write is accepted, the gate is locked again and bit 31 of address 0x3C reads 0.
- R6: A protected write made while the gate is locked is dropped. Nothing reaches the slow side and ready stays 1.
- R7: From the cycle after a protected write is accepted, ready reads 0. It returns to 1 only after the slow domain has acknowledged the transfer.
- R8: While ready is 0, key writes and protected writes are ignored. They change neither the open state nor what reaches the slow side.
- R9: Reads are not gated. At every address other than 0x3C, the read data equals the register file's read data. At address 0x00 the only difference is that bit 7 is replaced by ready. This holds whether the gate is open or locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset, fast domain |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 8 | Bus byte address, used for both reads and writes |
| bus_wdata | input | 32 | Bus write data |
| rf_rdata | input | 32 | Register file read data for bus_addr |
| bus_rdata | output | 32 | Read data returned to the bus |
| sclk | input | 1 | Slow register-file clock |
| srst | input | 1 | Synchronous active-high reset, slow domain |
| s_wr_valid | output | 1 | Single-cycle write strobe in the slow domain |
| s_wr_addr | output | 8 | Forwarded write address, held during the handshake |
| s_wr_data | output | 32 | Forwarded write data, held during the handshake |

## Verification
The hardest window to reach is the short period after a protected write is accepted, while the handshake is still on its way to the slow clock. The bench lands writes in that window by issuing a key write and then a second protected write on the very next bus cycles, which come long before any slow-clock acknowledge can return. Afterwards it confirms two things: the gate is still locked, and the slow side saw only the first write. The fast and slow clock periods are not multiples of each other, so the handshake lands at a different phase on each of the many forwarded writes in the address sweep.

// File: rtl/wkg_pkg.sv
package wkg_pkg;

    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned READY_BIT = 7;
    localparam int unsigned OPEN_BIT  = DATA_W - 1;

    localparam logic [ADDR_W-1:0] CTRL_ADDR   = 8'h00;
    localparam logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h3C;
    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0000_A55A;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_KEY  = 2'd1,
        ACC_PROT = 2'd2
    } bus_kind_e;

    function automatic bus_kind_e classify(input logic wr, input logic [ADDR_W-1:0] a);
        if (!wr)                  return ACC_NONE;
        else if (a == UNLOCK_ADDR) return ACC_KEY;
        else                       return ACC_PROT;
    endfunction

endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wkg_unlock.sv
module wkg_unlock
    import wkg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic              unlocked,
    output logic              accept
);
    assign accept = (kind == ACC_PROT) && unlocked && ready;

    always_ff @(posedge clk) begin
        if (rst)                            unlocked <= 1'b0;
        else if (kind == ACC_KEY && ready)  unlocked <= (wdata == UNLOCK_KEY);
        else if (accept)                    unlocked <= 1'b0;
    end

    AST_BAD_KEY_SHUTS: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_KEY && ready && wdata != UNLOCK_KEY) |=> !unlocked); // R3
    AST_RELOCK_ON_USE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !unlocked); // R5
    AST_BUSY_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_KEY && !ready) |=> $stable(unlocked)); // R8
endmodule

// File: rtl/wkg_tx.sv
module wkg_tx
    import wkg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  wr_cmd_t cmd_in,
    input  logic    ack_tgl,
    output logic    req_tgl,
    output wr_cmd_t cmd_q,
    output logic    busy
);
    logic ack_seen;

    wkg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            cmd_q   <= '0;
        end else if (accept) begin
            req_tgl <= ~req_tgl;
            cmd_q   <= cmd_in;
        end
    end

    assign busy = (req_tgl != ack_seen);

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept); // R8
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q)); // R4
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy); // R7
endmodule

// File: rtl/wkg_rx.sv
module wkg_rx #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic sclk,
    input  logic srst,
    input  logic req_tgl,
    output logic valid,
    output logic ack_tgl
);
    logic req_seen;

    wkg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (sclk),
        .rst (srst),
        .d   (req_tgl),
        .q   (req_seen)
    );

    always_ff @(posedge sclk) begin
        if (srst) ack_tgl <= 1'b0;
        else      ack_tgl <= req_seen;
    end

    assign valid = req_seen ^ ack_tgl;

    AST_ONE_STROBE: assert property (@(posedge sclk) disable iff (srst)
        valid |=> !valid); // R4
endmodule

// File: rtl/wr_key_gate.sv
module wr_key_gate
    import wkg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk,
    input  logic              srst,
    output logic              s_wr_valid,
    output logic [ADDR_W-1:0] s_wr_addr,
    output logic [DATA_W-1:0] s_wr_data
);
    bus_kind_e kind;
    logic      unlocked, accept, busy, ready, req_tgl, ack_tgl;
    wr_cmd_t   cmd_in, cmd_q;

    assign kind   = classify(bus_wr, bus_addr);
    assign ready  = !busy;
    assign cmd_in = '{addr: bus_addr, data: bus_wdata};

    wkg_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .wdata    (bus_wdata),
        .ready    (ready),
        .unlocked (unlocked),
        .accept   (accept)
    );

    wkg_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .cmd_in  (cmd_in),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .cmd_q   (cmd_q),
        .busy    (busy)
    );

    wkg_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .sclk    (sclk),
        .srst    (srst),
        .req_tgl (req_tgl),
        .valid   (s_wr_valid),
        .ack_tgl (ack_tgl)
    );

    assign s_wr_addr = cmd_q.addr;
    assign s_wr_data = cmd_q.data;

    always_comb begin
        bus_rdata = rf_rdata;
        if (bus_addr == UNLOCK_ADDR) begin
            bus_rdata           = '0;
            bus_rdata[OPEN_BIT] = unlocked;
        end else if (bus_addr == CTRL_ADDR) begin
            bus_rdata[READY_BIT] = ready;
        end
    end

    AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !unlocked); // R5
endmodule

// File: tb/wr_key_gate_tb.sv
module wr_key_gate_tb;
    import wkg_pkg::*;

    logic              clk = 1'b0, sclk = 1'b0, rst = 1'b1, srst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0, rf_rdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              s_wr_valid;
    logic [ADDR_W-1:0] s_wr_addr;
    logic [DATA_W-1:0] s_wr_data;

    int n_chk = 0, n_bad = 0, fwd_cnt = 0;
    logic [ADDR_W-1:0] last_a = '0;
    logic [DATA_W-1:0] last_d = '0;

    always #2  clk  = ~clk;
    always #17 sclk = ~sclk;

    wr_key_gate u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rf_rdata(rf_rdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .srst(srst), .s_wr_valid(s_wr_valid),
        .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data)
    );

    always @(negedge sclk) begin
        if (!srst && s_wr_valid) begin
            fwd_cnt = fwd_cnt + 1;
            last_a  = s_wr_addr;
            last_d  = s_wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdy_bit(output logic b);
        logic [DATA_W-1:0] v;
        rf_rdata = '0;
        rd(CTRL_ADDR, v);
        b = v[READY_BIT];
    endtask

    task automatic wait_rdy(input string req);
        logic b;
        b = 1'b0;
        for (int k = 0; k < 400 && !b; k++) rdy_bit(b);
        chk(req, {31'd0, b}, 32'd1);
    endtask

    localparam logic [DATA_W-1:0] OPEN_V = 32'h8000_0000;

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic              b;
        int                base;
        idle(60);
        rst = 1'b0; srst = 1'b0;
        idle(4);

        // R1: reset state
        rf_rdata = '0;
        rd(CTRL_ADDR, v);   chk("R1 ctrl", v, 32'h80);
        rd(UNLOCK_ADDR, v); chk("R1 open", v, 32'h0);
        chk("R1 nofwd", fwd_cnt, 0);

        // R9: reads in both states
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) wr(UNLOCK_ADDR, UNLOCK_KEY);
            for (int i = 0; i < 64; i++) begin
                logic [ADDR_W-1:0] a;
                logic [DATA_W-1:0] e;
                a = ADDR_W'(i * 4);
                rf_rdata = DATA_W'(i) * 32'h9E37_79B1 + 32'(pass);
                if (a == UNLOCK_ADDR)    e = (pass == 1) ? OPEN_V : 32'h0;
                else if (a == CTRL_ADDR) e = rf_rdata | 32'h80;
                else                     e = rf_rdata;
                rd(a, v);
                chk("R9 read", v, e);
            end
        end
        wr(UNLOCK_ADDR, 32'h0);
        rd(UNLOCK_ADDR, v); chk("R3 lock from open", v, 32'h0);

        // R2 / R3: key sweep, one bit off each time
        for (int bt = 0; bt < 32; bt++) begin
            wr(UNLOCK_ADDR, UNLOCK_KEY);
            rd(UNLOCK_ADDR, v); chk("R2 key opens", v, OPEN_V);
            wr(UNLOCK_ADDR, UNLOCK_KEY ^ (32'h1 << bt));
            rd(UNLOCK_ADDR, v); chk("R3 bad key", v, 32'h0);
        end
        wr(UNLOCK_ADDR, 32'h0000_5AA5);
        rd(UNLOCK_ADDR, v); chk("R3 bad key locked", v, 32'h0);
        rdy_bit(b); chk("R3 ready kept", {31'd0, b}, 32'd1);

        // R6: locked writes are dropped
        for (int i = 0; i < 64; i++) begin
            if (ADDR_W'(i * 4) == UNLOCK_ADDR) continue;
            wr(ADDR_W'(i * 4), 32'hDEAD_0000 + DATA_W'(i));
            rdy_bit(b); chk("R6 ready", {31'd0, b}, 32'd1);
        end
        idle(200);
        chk("R6 nofwd", fwd_cnt, 0);

        // R4 / R5 / R7: forwarded writes over every address
        for (int i = 0; i < 64; i++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            a = ADDR_W'(i * 4);
            if (a == UNLOCK_ADDR) continue;
            d = (DATA_W'(i) * 32'h0101_0101) ^ 32'hC0DE_0000;
            base = fwd_cnt;
            wr(UNLOCK_ADDR, UNLOCK_KEY);
            wr(a, d);
            rdy_bit(b);         chk("R7 ready low", {31'd0, b}, 32'd0);
            rd(UNLOCK_ADDR, v); chk("R5 relocked", v, 32'h0);
            wait_rdy("R7 ready back");
            chk("R4 count", fwd_cnt, base + 1);
            chk("R4 addr", {24'd0, last_a}, {24'd0, a});
            chk("R4 data", last_d, d);
        end

        // R8: writes during the busy window are ignored
        base = fwd_cnt;
        wr(UNLOCK_ADDR, UNLOCK_KEY);
        wr(8'h10, 32'h1111_2222);
        wr(UNLOCK_ADDR, UNLOCK_KEY);
        wr(8'h20, 32'h3333_4444);
        rdy_bit(b); chk("R8 busy", {31'd0, b}, 32'd0);
        wait_rdy("R8 ready back");
        rd(UNLOCK_ADDR, v); chk("R8 key ignored", v, 32'h0);
        idle(200);
        chk("R8 count", fwd_cnt, base + 1);
        chk("R8 addr", {24'd0, last_a}, 32'h10);
        chk("R8 data", last_d, 32'h1111_2222);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule